// File: doc/BRIEF.md
# Conditional Poll Wait Unit

This unit carries out one wait-on-condition command. On a start pulse it captures a command and reads a location through a request/response read port. The location is a register or a memory word. Each value returned is ANDed with a mask and compared, unsigned, against a reference using one of seven functions. The first success ends the command with `done`. After each failure the unit waits a programmable number of clock cycles and reads again. When the retry budget runs out without a success, the command ends with `timeout`. A retry budget of all ones removes the limit.

For register targets the command can be wrapped in writes. A register write of a supplied value goes out before the first read. A second write of another value goes out once the outcome is known, and the outcome is then reported. Command parsing and the register and memory fabrics are outside the unit. It only drives the request sides of a read port and a write port.

Top module: `poll_wait_unit`

## Requirements
- R1: The first read request is raised in the first cycle after an accepted `start`, without an interval wait. It presents the captured address, and `rd_mem` equals the captured target selector (1 memory, 0 register).
- R2: A read succeeds when (rd_data AND mask) relates to the reference, compared unsigned, as `func` selects: 0 always, 1 less than, 2 less or equal, 3 equal, 4 not equal, 5 greater or equal, 6 greater than.
- R3: Function code 7 behaves as "always", and `bad_func` is 1 from the cycle after that command starts until the next command starts.
- R4: On a success, `done` is high for exactly one cycle, `timeout` stays low, and no further read is requested.
- R5: With retry budget N (N below all ones), a command that never succeeds makes exactly N+1 reads. It then pulses `timeout` for one cycle and never pulses `done`.
- R6: A retry budget of all ones (12-bit 0xFFF) never times out. The unit keeps reading until a success.
- R7: With interval I, the next read request after a failed read is raised exactly I cycles after the response cycle. Consecutive accepted reads are therefore I+1 cycles apart.
- R8: With op code 1 and a register target, the unit writes `pre_data` to the address before the first read. After the final read it writes `post_data` to the address, and only then pulses `done` or `timeout`.
- R9: With a memory target, or with any op code other than 1, the unit issues no write.
- R10: A success on the last allowed read reports `done`, not `timeout`.
- R11: `busy` is high from the cycle after `start` until the outcome pulse. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a command (accepted when idle) |
| tgt_mem | input | 1 | Target selector: 1 memory, 0 register |
| func | input | 3 | Compare function code |
| op | input | 2 | Sequence code; 1 wraps the poll in register writes |
| addr | input | AW | Location to poll and to write |
| pre_data | input | DW | Value written before polling (op 1) |
| post_data | input | DW | Value written after polling (op 1) |
| reference | input | DW | Comparison reference |
| mask | input | DW | Mask applied to the value read |
| retry_max | input | RW | Retry budget; all ones means unlimited |
| interval | input | IW | Idle cycles between a failed read and the next |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_mem | output | 1 | Read targets memory (1) or a register (0) |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read response valid; data in the same cycle |
| rd_data | input | DW | Read response data |
| wr_req | output | 1 | Register write request, held until acknowledged |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| wr_ack | input | 1 | Write accepted |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse: condition met |
| timeout | output | 1 | One-cycle pulse: retry budget exhausted |
| bad_func | output | 1 | Last command used the reserved function code |

## Verification
Two events can fall in the same response cycle: a successful compare and the exhaustion of the retry budget. The bench provokes this by returning a matching value on exactly the final allowed read. It expects `done` alone, after N+1 reads. A second case does the same under the write-wrapped sequence, where the outcome has to survive the post-write before it is reported.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [2:0] {
    FN_ALWAYS = 3'd0,
    FN_LT     = 3'd1,
    FN_LE     = 3'd2,
    FN_EQ     = 3'd3,
    FN_NE     = 3'd4,
    FN_GE     = 3'd5,
    FN_GT     = 3'd6,
    FN_RSVD   = 3'd7
  } pw_func_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_READ = 3'd2,
    ST_WAIT = 3'd3,
    ST_POST = 3'd4
  } pw_state_e;

  localparam logic [1:0] OP_WRAP = 2'b01;
endpackage

// File: rtl/pw_compare.sv
module pw_compare #(
  parameter int DW = 32
) (
  input  logic [2:0]    func,
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] reference,
  output logic          hit
);
  import pw_pkg::*;

  function automatic logic eval(input logic [2:0] f, input logic [DW-1:0] v, input logic [DW-1:0] r);
    logic res;
    case (pw_func_e'(f))
      FN_LT:   res = (v <  r);
      FN_LE:   res = (v <= r);
      FN_EQ:   res = (v == r);
      FN_NE:   res = (v != r);
      FN_GE:   res = (v >= r);
      FN_GT:   res = (v >  r);
      default: res = 1'b1;
    endcase
    return res;
  endfunction

  assign hit = eval(func, value & mask, reference);
endmodule

// File: rtl/pw_retry.sv
module pw_retry #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [RW-1:0] budget,
  input  logic          consume,
  output logic          exhausted,
  output logic          unlimited
);
  logic [RW-1:0] left_q;
  logic          inf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      inf_q  <= 1'b0;
    end else if (load) begin
      left_q <= budget;
      inf_q  <= (budget == {RW{1'b1}});
    end else if (consume && !inf_q && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign exhausted = !inf_q && (left_q == '0);
  assign unlimited = inf_q;
endmodule

// File: rtl/pw_interval.sv
module pw_interval #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_cfg,
  input  logic [IW-1:0] cfg,
  input  logic          arm,
  input  logic          tick,
  output logic          skip,
  output logic          expire
);
  logic [IW-1:0] len_q;
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_cfg) len_q <= cfg;
      if (arm) cnt_q <= len_q;
      else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign skip   = (len_q == '0);
  assign expire = (cnt_q <= {{(IW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/poll_wait_unit.sv
module poll_wait_unit #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int RW = 12,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tgt_mem,
  input  logic [2:0]    func,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] pre_data,
  input  logic [DW-1:0] post_data,
  input  logic [DW-1:0] reference,
  input  logic [DW-1:0] mask,
  input  logic [RW-1:0] retry_max,
  input  logic [IW-1:0] interval,
  output logic          rd_req,
  output logic          rd_mem,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          bad_func
);
  import pw_pkg::*;

  pw_state_e     state_q, state_d;
  logic [2:0]    func_q;
  logic          mem_q, wrap_q, hit_q, done_q, tout_q, bad_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] pre_q, post_q, ref_q, mask_q;

  // named internal events
  logic evt_start, evt_resp, evt_hit, evt_miss, evt_retry, evt_final, evt_finish;
  logic cmp_hit, retry_out, retry_inf, ivl_skip, ivl_expire, outcome_hit;

  pw_compare #(.DW(DW)) u_cmp (
    .func(func_q), .value(rd_data), .mask(mask_q), .reference(ref_q), .hit(cmp_hit)
  );

  pw_retry #(.RW(RW)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(evt_start), .budget(retry_max),
    .consume(evt_retry), .exhausted(retry_out), .unlimited(retry_inf)
  );

  pw_interval #(.IW(IW)) u_ivl (
    .clk(clk), .rst_n(rst_n), .load_cfg(evt_start), .cfg(interval),
    .arm(evt_retry), .tick(state_q == ST_WAIT), .skip(ivl_skip), .expire(ivl_expire)
  );

  assign evt_start  = start && (state_q == ST_IDLE);
  assign evt_resp   = (state_q == ST_READ) && rd_ack;
  assign evt_hit    = evt_resp && cmp_hit;
  assign evt_miss   = evt_resp && !cmp_hit;
  assign evt_retry  = evt_miss && !retry_out;
  assign evt_final  = evt_hit || (evt_miss && retry_out);
  assign evt_finish = (evt_final && !wrap_q) || ((state_q == ST_POST) && wr_ack);
  assign outcome_hit = (state_q == ST_READ) ? cmp_hit : hit_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (evt_start) state_d = (op == OP_WRAP && !tgt_mem) ? ST_PRE : ST_READ;
      ST_PRE:  if (wr_ack) state_d = ST_READ;
      ST_READ: begin
        if (evt_final)      state_d = wrap_q ? ST_POST : ST_IDLE;
        else if (evt_retry) state_d = ivl_skip ? ST_READ : ST_WAIT;
      end
      ST_WAIT: if (ivl_expire) state_d = ST_READ;
      ST_POST: if (wr_ack) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      func_q  <= '0;
      mem_q   <= 1'b0;
      wrap_q  <= 1'b0;
      hit_q   <= 1'b0;
      addr_q  <= '0;
      pre_q   <= '0;
      post_q  <= '0;
      ref_q   <= '0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      tout_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= evt_finish && outcome_hit;
      tout_q  <= evt_finish && !outcome_hit;
      if (evt_resp) hit_q <= cmp_hit;
      if (evt_start) begin
        func_q <= func;
        mem_q  <= tgt_mem;
        wrap_q <= (op == OP_WRAP) && !tgt_mem;
        addr_q <= addr;
        pre_q  <= pre_data;
        post_q <= post_data;
        ref_q  <= reference;
        mask_q <= mask;
        bad_q  <= (func == FN_RSVD);
      end
    end
  end

  assign rd_req   = (state_q == ST_READ);
  assign rd_mem   = mem_q;
  assign rd_addr  = addr_q;
  assign wr_req   = (state_q == ST_PRE) || (state_q == ST_POST);
  assign wr_addr  = addr_q;
  assign wr_data  = (state_q == ST_POST) ? post_q : pre_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign timeout  = tout_q;
  assign bad_func = bad_q;
endmodule

// File: rtl/pw_checker.sv
module pw_checker (
  input logic clk,
  input logic rst_n,
  input logic rd_req,
  input logic rd_ack,
  input logic wr_req,
  input logic wr_ack,
  input logic busy,
  input logic done,
  input logic timeout,
  input logic mem_q,
  input logic retry_inf
);
  p_single_outcome_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_read_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req);

  p_write_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req);

  p_port_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  p_no_mem_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> !mem_q);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req && !wr_req));

  p_outcome_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> ($past(busy) && !busy));

  p_unlimited_no_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_inf |-> !timeout);
endmodule

bind poll_wait_unit pw_checker u_pw_checker (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_ack(rd_ack),
  .wr_req(wr_req), .wr_ack(wr_ack), .busy(busy), .done(done),
  .timeout(timeout), .mem_q(mem_q), .retry_inf(retry_inf)
);

// File: tb/test_poll_wait_unit.sv
module test_poll_wait_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, tgt_mem = 1'b0;
  logic [2:0]  func = 3'd0;
  logic [1:0]  op = 2'd0;
  logic [31:0] addr = '0, pre_data = '0, post_data = '0, reference = '0, mask = '0;
  logic [11:0] retry_max = '0;
  logic [15:0] interval = '0;
  logic        rd_req, rd_mem, rd_ack = 1'b0, wr_req, wr_ack = 1'b0;
  logic [31:0] rd_addr, rd_data = '0, wr_addr, wr_data;
  logic        busy, done, timeout, bad_func;

  always #2 clk = ~clk;

  poll_wait_unit i_poll_wait_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_mem(tgt_mem), .func(func), .op(op),
    .addr(addr), .pre_data(pre_data), .post_data(post_data), .reference(reference),
    .mask(mask), .retry_max(retry_max), .interval(interval),
    .rd_req(rd_req), .rd_mem(rd_mem), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .timeout(timeout), .bad_func(bad_func)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  int reads = 0, writes = 0, hit_at = 0;
  int last_rd_cyc = 0, gap_min = 0, gap_max = 0;
  int reads_at_first_wr = 0, reads_at_last_wr = 0;
  logic [31:0] first_wr_data, last_wr_data, first_wr_addr;
  logic [31:0] miss_val = '0, hit_val = '0;
  logic got_done, got_tout;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // responders: acknowledge any pending request in the following posedge
  always @(negedge clk) begin
    rd_ack  <= rd_req;
    rd_data <= (reads == hit_at) ? hit_val : miss_val;
    wr_ack  <= wr_req;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_req && rd_ack) begin
      if (reads > 0) begin
        if (gap_min == 0 || cyc - last_rd_cyc < gap_min) gap_min <= cyc - last_rd_cyc;
        if (cyc - last_rd_cyc > gap_max) gap_max <= cyc - last_rd_cyc;
      end
      last_rd_cyc <= cyc;
      reads <= reads + 1;
    end
    if (wr_req && wr_ack) begin
      if (writes == 0) begin
        first_wr_data <= wr_data;
        first_wr_addr <= wr_addr;
        reads_at_first_wr <= reads;
      end
      last_wr_data <= wr_data;
      reads_at_last_wr <= reads;
      writes <= writes + 1;
    end
  end

  initial begin
    #800000;
    n_fail++;
    n_run++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  function automatic bit ref_model(input int f, input logic [31:0] v, input logic [31:0] r);
    longint unsigned a = longint'(v), b = longint'(r);
    if (f == 1) return a < b;
    if (f == 2) return !(a > b);
    if (f == 3) return a == b;
    if (f == 4) return a != b;
    if (f == 5) return !(a < b);
    if (f == 6) return a > b;
    return 1'b1;
  endfunction

  // issue one command and wait for its outcome; first_req/first_busy from the cycle after start
  task automatic run(input bit mem, input int f, input int o, input logic [31:0] rv, input logic [31:0] mk,
                     input int rt, input int iv, output bit first_req, output bit first_busy);
    int guard = 0;
    @(negedge clk);
    reads = 0; writes = 0; gap_min = 0; gap_max = 0;
    tgt_mem = mem; func = 3'(f); op = 2'(o); reference = rv; mask = mk;
    retry_max = 12'(rt); interval = 16'(iv);
    addr = 32'h0000_4A10; pre_data = 32'h1111_0001; post_data = 32'h2222_0002;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_req = rd_req;
    first_busy = busy;
    got_done = 1'b0; got_tout = 1'b0;
    while (!(done || timeout) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    got_done = done; got_tout = timeout;
    @(negedge clk);
    chk(!done && !timeout, "R4 outcome is a single-cycle pulse", done, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !timeout && !rd_req && !wr_req, "R11 reset idle", busy, 0);
  endtask

  task automatic t_first_read;
    bit fr, fb;
    hit_at = 0; hit_val = 32'd9; miss_val = 32'd0;
    run(1'b1, 3, 0, 32'd9, '1, 0, 7, fr, fb);
    chk(fr, "R1 first read without interval", fr, 1);
    chk(fb, "R11 busy after start", fb, 1);
    chk(got_done && !got_tout, "R4 match gives done", got_done, 1);
    chk(reads == 1, "R4 no read after match", reads, 1);
  endtask

  task automatic t_rd_mem_addr;
    bit fr, fb;
    hit_at = 2; hit_val = 32'd5; miss_val = 32'd0;
    fork
      run(1'b0, 3, 0, 32'd5, '1, 4, 0, fr, fb);
      begin
        @(posedge rd_req); #1;
        chk(rd_mem == 1'b0 && rd_addr == 32'h0000_4A10, "R1 register target and address", rd_mem, 0);
      end
    join
  endtask

  task automatic t_functions;
    bit fr, fb;
    logic [31:0] vals [3] = '{32'd50, 32'd100, 32'hF000_0000};
    for (int f = 0; f < 7; f++) begin
      for (int k = 0; k < 3; k++) begin
        bit e;
        hit_at = 0; hit_val = vals[k]; miss_val = vals[k];
        e = ref_model(f, vals[k], 32'd100);
        run(1'b1, f, 0, 32'd100, '1, 0, 0, fr, fb);
        chk(got_done == e && got_tout == !e, $sformatf("R2 func %0d value %0h", f, vals[k]), got_done, e);
      end
    end
  endtask

  task automatic t_mask;
    bit fr, fb;
    hit_at = 0; hit_val = 32'hABCD_0042; miss_val = hit_val;
    run(1'b1, 3, 0, 32'h0000_0042, 32'h0000_FFFF, 0, 0, fr, fb);
    chk(got_done, "R2 mask removes upper bits", got_done, 1);
    run(1'b1, 3, 0, 32'hABCD_0042, 32'h0000_FFFF, 0, 0, fr, fb);
    chk(got_tout, "R2 mask applied before equality", got_tout, 1);
  endtask

  task automatic t_exhaust;
    bit fr, fb;
    hit_at = -1; miss_val = 32'd1;
    run(1'b1, 3, 0, 32'd2, '1, 3, 2, fr, fb);
    chk(got_tout && !got_done, "R5 timeout after budget", got_tout, 1);
    chk(reads == 4, "R5 read count is budget plus one", reads, 4);
  endtask

  task automatic t_interval;
    bit fr, fb;
    hit_at = 2; hit_val = 32'd7; miss_val = 32'd1;
    run(1'b1, 3, 0, 32'd7, '1, 10, 5, fr, fb);
    chk(gap_min == 6 && gap_max == 6, "R7 read spacing interval plus one", gap_max, 6);
    run(1'b1, 3, 0, 32'd7, '1, 10, 0, fr, fb);
    chk(gap_min == 1 && gap_max == 1, "R7 zero interval back to back", gap_max, 1);
  endtask

  task automatic t_forever;
    bit fr, fb;
    hit_at = 4200; hit_val = 32'd3; miss_val = 32'd0;
    run(1'b1, 3, 0, 32'd3, '1, 12'hFFF, 0, fr, fb);
    chk(got_done && !got_tout, "R6 unlimited retry reaches match", got_done, 1);
    chk(reads == 4201, "R6 read count beyond 12-bit budget", reads, 4201);
  endtask

  task automatic t_wrap_reg;
    bit fr, fb;
    hit_at = -1; miss_val = 32'd0;
    run(1'b0, 3, 1, 32'd1, '1, 2, 1, fr, fb);
    chk(!fr, "R8 write precedes first read", fr, 0);
    chk(writes == 2, "R8 two writes", writes, 2);
    chk(first_wr_data == 32'h1111_0001 && first_wr_addr == 32'h0000_4A10, "R8 pre write data", first_wr_data, 32'h1111_0001);
    chk(reads_at_first_wr == 0, "R8 pre write before reads", reads_at_first_wr, 0);
    chk(last_wr_data == 32'h2222_0002 && reads_at_last_wr == 3, "R8 post write after last read", last_wr_data, 32'h2222_0002);
    chk(got_tout, "R8 timeout after post write", got_tout, 1);
  endtask

  task automatic t_wrap_mem_and_plain;
    bit fr, fb;
    hit_at = 1; hit_val = 32'd4; miss_val = 32'd0;
    run(1'b1, 3, 1, 32'd4, '1, 3, 0, fr, fb);
    chk(writes == 0 && got_done, "R9 memory target makes no write", writes, 0);
    run(1'b0, 3, 2, 32'd4, '1, 3, 0, fr, fb);
    chk(writes == 0 && got_done, "R9 op other than 1 makes no write", writes, 0);
  endtask

  task automatic t_reserved_func;
    bit fr, fb;
    hit_at = 0; hit_val = 32'd0; miss_val = 32'd0;
    run(1'b1, 7, 0, 32'd55, '1, 0, 0, fr, fb);
    chk(got_done && reads == 1, "R3 code 7 acts as always", got_done, 1);
    chk(bad_func, "R3 reserved code flagged", bad_func, 1);
    run(1'b1, 0, 0, 32'd55, '1, 0, 0, fr, fb);
    chk(!bad_func, "R3 flag clears on next command", bad_func, 0);
  endtask

  task automatic t_last_retry_hit;
    bit fr, fb;
    hit_at = 3; hit_val = 32'd8; miss_val = 32'd1;
    run(1'b1, 3, 0, 32'd8, '1, 3, 1, fr, fb);
    chk(got_done && !got_tout && reads == 4, "R10 match on last read wins", got_done, 1);
    run(1'b0, 3, 1, 32'd8, '1, 3, 0, fr, fb);
    chk(got_done && !got_tout && writes == 2, "R10 match on last read under wrap", got_done, 1);
  endtask

  task automatic t_start_while_busy;
    bit fr, fb;
    hit_at = 2; hit_val = 32'd6; miss_val = 32'd0;
    fork
      run(1'b1, 3, 0, 32'd6, '1, 5, 3, fr, fb);
      begin
        repeat (4) @(negedge clk);
        start = 1'b1; func = 3'd0; retry_max = 12'd0;
        @(negedge clk);
        start = 1'b0;
      end
    join
    chk(got_done && reads == 3, "R11 start while busy ignored", reads, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_first_read();
    t_rd_mem_addr();
    t_functions();
    t_mask();
    t_exhaust();
    t_interval();
    t_forever();
    t_wrap_reg();
    t_wrap_mem_and_plain();
    t_reserved_func();
    t_last_retry_hit();
    t_start_while_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule